// File: doc/BRIEF.md
# Display Power and Dot-Clock Sequencer

This block brings a two-channel display controller up and down in an orderly way. Software writes a control word holding a run bit, one enable per channel, a pixel-source select and a reset request. The block then ramps each enabled channel's panel power through an intermediate step to fully on, or back down to off. Each channel's progress is visible in a 2-bit status field. A separate dot-clock stop register halts the pixel clock at once. After a restart it reads back as stopped until the clock is actually running again, so software can poll one bit instead of timing the restart itself.

The reset request clears itself. While it is pending, every control field reads zero, channel power is held off, and control writes are ignored. The spacing between power steps comes from an input, so board code can match the panel's supply ramp.

Top module: `disp_pwr_seq`

## Requirements
- R1: After the synchronous reset, the control register reads 0, both status fields read 0, the dot-clock stop register reads 0 and `dot_clk_en` is 1.
- R2: Control register (address 0) layout: bit 0 run, bit 1 main-channel enable, bit 2 secondary-channel enable, bit 3 pixel source (1 = internal blending unit, driven on `src_blend`), bit 8 reset request. Bits 4 to 7 are not stored and read 0.
- R3: With run and enable set, a channel's status goes 0 to 1 at the (G+2)th clock edge after the write edge and 1 to 3 after G+1 more edges, where G is `step_gap`.
- R4: Clearing run steps an enabled channel 3 to 1 and then 1 to 0, with the same edge counts as R3.
- R5: A channel whose enable bit is clear keeps its status unchanged, whatever the run bit does.
- R6: A run-bit change in mid-ramp reverses the ramp from the current step. The next step toward the new target comes G+2 edges after the write edge.
- R7: Writing 1 to bit 8 zeroes every other control field at once. Bit 8 then reads 1 for exactly RST_CYC cycles and clears itself, and both status fields are 0 from the cycle after the request until it clears.
- R8: Control writes that arrive while a reset request is pending have no effect.
- R9: Writing 1 to bit 0 of the dot-clock stop register (address 1) drops `dot_clk_en` on the next cycle, and the register then reads 1.
- R10: Writing 0 there while the clock is stopped raises `dot_clk_en` exactly RESTART_CYC edges after the write edge. The register reads 1 until the clock is running and 0 from then on. Writing 0 while the clock is running changes nothing.
- R11: The status register (address 2) holds the main channel's status in bits 1:0 and the secondary channel's in bits 3:2, matching `chan_pwr_st`. A status field never holds the value 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 dot-clock stop |
| wr_data | input | 9 | Write data |
| rd_addr | input | 2 | Read address: 0 control, 1 dot-clock stop, 2 status |
| rd_data | output | 9 | Combinational read data |
| step_gap | input | 4 | Extra idle cycles between power steps |
| dot_clk_en | output | 1 | Dot clock running |
| src_blend | output | 1 | Pixel source is the internal blending unit |
| chan_pwr_st | output | 4 | Power status, main in 1:0, secondary in 3:2 |

## Verification
A ramp counter that is not cleared on a reversal, or that starts one cycle late, moves the status field one edge away from G+2 or G+1. The exact-cycle status samples catch this at the first step. A channel that is sequenced while disabled shows a status that changes where it should hold. A missing clear during a reset request leaves a nonzero status within one cycle of the request. A restart counter that is off by one raises `dot_clk_en` one edge early or late. The stop register readback exposes the same error on the read port in the same cycle.

// File: rtl/disp_seq_pkg.sv
package disp_seq_pkg;

    localparam int DATA_W = 9;
    localparam int ADDR_W = 2;
    localparam int NUM_CH = 2;

    localparam int BIT_RUN   = 0;
    localparam int BIT_EN0   = 1;
    localparam int BIT_EN1   = 2;
    localparam int BIT_BLEND = 3;
    localparam int BIT_RESET = 8;

    localparam logic [DATA_W-1:0] CTRL_KEEP = 9'h10F;

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL    = 2'd0,
        RA_CLKSTOP = 2'd1,
        RA_STATUS  = 2'd2
    } reg_addr_e;

    typedef enum logic [1:0] {
        PWR_OFF  = 2'd0,
        PWR_PART = 2'd1,
        PWR_ON   = 2'd3
    } pwr_st_e;

    typedef struct packed {
        logic              rst_req;
        logic              blend;
        logic [NUM_CH-1:0] en;
        logic              run;
    } ctrl_t;

    function automatic ctrl_t ctrl_unpack(logic [DATA_W-1:0] w);
        ctrl_t c;
        logic [DATA_W-1:0] m;
        m         = w & CTRL_KEEP;
        c.run     = m[BIT_RUN];
        c.en      = {m[BIT_EN1], m[BIT_EN0]};
        c.blend   = m[BIT_BLEND];
        c.rst_req = m[BIT_RESET];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_pack(ctrl_t c);
        logic [DATA_W-1:0] w;
        w            = '0;
        w[BIT_RUN]   = c.run;
        w[BIT_EN0]   = c.en[0];
        w[BIT_EN1]   = c.en[1];
        w[BIT_BLEND] = c.blend;
        w[BIT_RESET] = c.rst_req;
        return w;
    endfunction

    function automatic pwr_st_e step_toward(pwr_st_e cur, logic up);
        case (cur)
            PWR_OFF:  return up ? PWR_PART : PWR_OFF;
            PWR_PART: return up ? PWR_ON   : PWR_OFF;
            default:  return up ? PWR_ON   : PWR_PART;
        endcase
    endfunction

endpackage

// File: rtl/dps_ctrl_reg.sv
module dps_ctrl_reg
    import disp_seq_pkg::*;
#(
    parameter int RST_CYC = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    output ctrl_t             ctrl,
    output logic              busy
);
    localparam int CW = $clog2(RST_CYC + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            cnt  <= '0;
        end else if (ctrl.rst_req) begin
            if (cnt == '0) begin
                ctrl.rst_req <= 1'b0;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end else if (wr_stb) begin
            if (wr_data[BIT_RESET]) begin
                ctrl         <= '0;
                ctrl.rst_req <= 1'b1;
                cnt          <= CW'(RST_CYC - 1);
            end else begin
                ctrl <= ctrl_unpack(wr_data);
            end
        end
    end

    assign busy = ctrl.rst_req;

endmodule

// File: rtl/dps_chan_ramp.sv
module dps_chan_ramp
    import disp_seq_pkg::*;
#(
    parameter int GAP_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             en,
    input  logic             run,
    input  logic [GAP_W-1:0] gap,
    output pwr_st_e          st
);
    pwr_st_e          tgt;
    pwr_st_e          tgt_q;
    logic [GAP_W-1:0] cnt;

    assign tgt = run ? PWR_ON : PWR_OFF;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            st    <= PWR_OFF;
            tgt_q <= PWR_OFF;
            cnt   <= '0;
        end else begin
            tgt_q <= tgt;
            if (tgt != tgt_q) begin
                cnt <= '0;
            end else if (en && (st != tgt)) begin
                if (cnt == gap) begin
                    st  <= step_toward(st, run);
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end else begin
                cnt <= '0;
            end
        end
    end

endmodule

// File: rtl/dps_clk_gate.sv
module dps_clk_gate #(
    parameter int RESTART_CYC = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic wr_stb,
    input  logic halt,
    output logic clk_en
);
    localparam int CW = $clog2(RESTART_CYC + 1);

    logic          pend;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_en <= 1'b1;
            pend   <= 1'b0;
            cnt    <= '0;
        end else if (wr_stb) begin
            if (halt) begin
                clk_en <= 1'b0;
                pend   <= 1'b0;
            end else if (!clk_en && !pend) begin
                pend <= 1'b1;
                cnt  <= CW'(RESTART_CYC - 1);
            end
        end else if (pend) begin
            if (cnt == '0) begin
                clk_en <= 1'b1;
                pend   <= 1'b0;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

endmodule

// File: rtl/disp_pwr_seq.sv
module disp_pwr_seq
    import disp_seq_pkg::*;
#(
    parameter int GAP_W       = 4,
    parameter int RST_CYC     = 4,
    parameter int RESTART_CYC = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [GAP_W-1:0]  step_gap,
    output logic              dot_clk_en,
    output logic              src_blend,
    output logic [2*NUM_CH-1:0] chan_pwr_st
);
    ctrl_t ctrl;
    logic  rst_busy;
    logic  ctrl_stb;
    logic  clk_stb;

    assign ctrl_stb = wr_en && (reg_addr_e'(wr_addr) == RA_CTRL);
    assign clk_stb  = wr_en && (reg_addr_e'(wr_addr) == RA_CLKSTOP);

    dps_ctrl_reg #(.RST_CYC(RST_CYC)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_stb  (ctrl_stb),
        .wr_data (wr_data),
        .ctrl    (ctrl),
        .busy    (rst_busy)
    );

    dps_clk_gate #(.RESTART_CYC(RESTART_CYC)) u_clk (
        .clk    (clk),
        .rst    (rst),
        .wr_stb (clk_stb),
        .halt   (wr_data[0]),
        .clk_en (dot_clk_en)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        pwr_st_e st_i;
        dps_chan_ramp #(.GAP_W(GAP_W)) u_ramp (
            .clk (clk),
            .rst (rst),
            .clr (rst_busy),
            .en  (ctrl.en[i]),
            .run (ctrl.run),
            .gap (step_gap),
            .st  (st_i)
        );
        assign chan_pwr_st[2*i +: 2] = st_i;
    end

    assign src_blend = ctrl.blend;

    always_comb begin
        case (reg_addr_e'(rd_addr))
            RA_CTRL:    rd_data = ctrl_pack(ctrl);
            RA_CLKSTOP: rd_data = DATA_W'(!dot_clk_en);
            RA_STATUS:  rd_data = DATA_W'(chan_pwr_st);
            default:    rd_data = '0;
        endcase
    end

endmodule

// File: rtl/disp_pwr_seq_chk.sv
module disp_pwr_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [1:0] wr_addr,
    input logic [8:0] wr_data,
    input logic       dot_clk_en,
    input logic [3:0] chan_pwr_st,
    input logic       busy,
    input logic [1:0] ch_en
);
    // R11: the code 2 never appears in a status field
    p_no_code_two_r11: assert property (@(posedge clk) disable iff (rst)
        (chan_pwr_st[1:0] != 2'd2) && (chan_pwr_st[3:2] != 2'd2));

    // R3 / R4: the main channel moves one ramp step at a time, or is cleared
    p_single_step_r3: assert property (@(posedge clk) disable iff (rst)
        (chan_pwr_st[1:0] != $past(chan_pwr_st[1:0])) |->
            ((chan_pwr_st[1:0] == 2'd0) ||
             ($past(chan_pwr_st[1:0]) == 2'd0 && chan_pwr_st[1:0] == 2'd1) ||
             ($past(chan_pwr_st[1:0]) == 2'd3 && chan_pwr_st[1:0] == 2'd1) ||
             ($past(chan_pwr_st[1:0]) == 2'd1 && chan_pwr_st[1:0] == 2'd3)));

    // R5: a disabled channel holds its status
    p_disabled_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!ch_en[1] && !busy) |=> $stable(chan_pwr_st[3:2]));

    // R7: power is held off while a reset request is pending
    p_busy_off_r7: assert property (@(posedge clk) disable iff (rst)
        busy |=> (chan_pwr_st == 4'd0));

    // R9: a halt write stops the dot clock on the next cycle
    p_halt_now_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 2'd1 && wr_data[0]) |=> !dot_clk_en);

    // R10: a restart never completes on the cycle after the write
    p_restart_delay_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 2'd1 && !wr_data[0] && !dot_clk_en) |=> !dot_clk_en);

endmodule

bind disp_pwr_seq disp_pwr_seq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .dot_clk_en  (dot_clk_en),
    .chan_pwr_st (chan_pwr_st),
    .busy        (rst_busy),
    .ch_en       (ctrl.en)
);

// File: tb/disp_pwr_seq_tb.sv
module disp_pwr_seq_tb;
    localparam int CLK_P   = 10;
    localparam int G       = 3;
    localparam int RSTC    = 4;
    localparam int RESTART = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [8:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [8:0] rd_data;
    logic [3:0] step_gap = 4'(G);
    logic       dot_clk_en;
    logic       src_blend;
    logic [3:0] chan_pwr_st;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_P/2) clk = ~clk;

    disp_pwr_seq #(.GAP_W(4), .RST_CYC(RSTC), .RESTART_CYC(RESTART)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .step_gap(step_gap),
        .dot_clk_en(dot_clk_en), .src_blend(src_blend), .chan_pwr_st(chan_pwr_st)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [8:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int d);
        rd_addr = a;
        #1;
        d = int'(rd_data);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic hard_reset();
        @(negedge clk);
        rst = 1'b1;
        wait_cyc(2);
        rst = 1'b0;
    endtask

    task automatic t_reset_state();
        int v;
        hard_reset();
        rd(2'd0, v); chk("R1 ctrl", v, 0);
        rd(2'd2, v); chk("R1 status", v, 0);
        rd(2'd1, v); chk("R1 clkstop", v, 0);
        chk("R1 dot_clk_en", int'(dot_clk_en), 1);
    endtask

    task automatic t_ctrl_fields();
        int v;
        hard_reset();
        wr(2'd0, 9'h008);
        chk("R2 src_blend", int'(src_blend), 1);
        rd(2'd0, v); chk("R2 ctrl readback", v, 'h008);
        wait_cyc(2*G + 4);
        chk("R2 no run no ramp", int'(chan_pwr_st), 0);
        wr(2'd0, 9'h0FE);
        rd(2'd0, v); chk("R2 reserved bits dropped", v, 'h00E);
    endtask

    task automatic t_power_up();
        int v;
        hard_reset();
        wr(2'd0, 9'h007);
        wait_cyc(G + 1); chk("R3 before first step", int'(chan_pwr_st), 'h0);
        wait_cyc(1);     chk("R3 first step", int'(chan_pwr_st), 'h5);
        rd(2'd2, v);     chk("R11 status register layout", v, 'h5);
        wait_cyc(G);     chk("R3 before second step", int'(chan_pwr_st), 'h5);
        wait_cyc(1);     chk("R3 fully on", int'(chan_pwr_st), 'hF);
        rd(2'd2, v);     chk("R11 status register on", v, 'hF);
    endtask

    task automatic t_power_down();
        hard_reset();
        wr(2'd0, 9'h007);
        wait_cyc(2*G + 3);
        wr(2'd0, 9'h006);
        wait_cyc(G + 1); chk("R4 before first down step", int'(chan_pwr_st), 'hF);
        wait_cyc(1);     chk("R4 down to 1", int'(chan_pwr_st), 'h5);
        wait_cyc(G);     chk("R4 before off", int'(chan_pwr_st), 'h5);
        wait_cyc(1);     chk("R4 off", int'(chan_pwr_st), 'h0);
    endtask

    task automatic t_disabled_hold();
        hard_reset();
        wr(2'd0, 9'h003);
        wait_cyc(2*G + 3);
        chk("R5 secondary disabled stays off", int'(chan_pwr_st), 'h3);
        wr(2'd0, 9'h007);
        wait_cyc(2*G + 3);
        chk("R5 both on", int'(chan_pwr_st), 'hF);
        wr(2'd0, 9'h002);
        wait_cyc(2*G + 4);
        chk("R5 disabled secondary holds on", int'(chan_pwr_st), 'hC);
    endtask

    task automatic t_reversal();
        hard_reset();
        wr(2'd0, 9'h007);
        wait_cyc(G + 2);
        chk("R6 mid ramp", int'(chan_pwr_st), 'h5);
        wr(2'd0, 9'h006);
        wait_cyc(G + 1); chk("R6 holds before reverse step", int'(chan_pwr_st), 'h5);
        wait_cyc(1);     chk("R6 reversed to off", int'(chan_pwr_st), 'h0);
    endtask

    task automatic t_soft_reset();
        int v;
        hard_reset();
        wr(2'd0, 9'h00F);
        wait_cyc(2*G + 3);
        wr(2'd0, 9'h107);
        rd(2'd0, v); chk("R7 request clears other fields", v, 'h100);
        chk("R7 blend cleared", int'(src_blend), 0);
        wait_cyc(RSTC - 1);
        rd(2'd0, v); chk("R7 request still pending", v, 'h100);
        chk("R7 power held off", int'(chan_pwr_st), 0);
        wait_cyc(1);
        rd(2'd0, v); chk("R7 self cleared", v, 0);
    endtask

    task automatic t_write_during_reset();
        int v;
        hard_reset();
        wr(2'd0, 9'h100);
        wr(2'd0, 9'h00F);
        wait_cyc(RSTC);
        rd(2'd0, v); chk("R8 write during reset ignored", v, 0);
        wait_cyc(2*G + 4);
        chk("R8 no ramp after ignored write", int'(chan_pwr_st), 0);
    endtask

    task automatic t_clk_halt_restart();
        int v;
        hard_reset();
        wr(2'd1, 9'h001);
        chk("R9 dot clock halted", int'(dot_clk_en), 0);
        rd(2'd1, v); chk("R9 stop readback", v, 1);
        wait_cyc(3);
        chk("R9 stays halted", int'(dot_clk_en), 0);
        wr(2'd1, 9'h000);
        wait_cyc(RESTART - 1);
        chk("R10 not yet running", int'(dot_clk_en), 0);
        rd(2'd1, v); chk("R10 readback while restarting", v, 1);
        wait_cyc(1);
        chk("R10 running", int'(dot_clk_en), 1);
        rd(2'd1, v); chk("R10 readback running", v, 0);
        wr(2'd1, 9'h000);
        wait_cyc(2);
        chk("R10 restart while running no effect", int'(dot_clk_en), 1);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        t_reset_state();
        t_ctrl_fields();
        t_power_up();
        t_power_down();
        t_disabled_hold();
        t_reversal();
        t_soft_reset();
        t_write_during_reset();
        t_clk_halt_restart();
        finish_run();
    end

endmodule